// File: doc/BRIEF.md
# Write-Through Data Cache with Burst Line Fill

This block is a small direct-mapped data cache placed between a 32-bit CPU load/store port and a memory bus. Each tag holds the upper logical address bits together with a one-bit privilege code, so user-mode and supervisor-mode accesses to the same address occupy different entries. Stores are always forwarded to memory. The cache has no dirty state, so it never has to write lines back.

Control inputs select the operating mode. One input enables the cache and another freezes it. A further input turns on four-beat line fills, and another selects write-allocate mode. A one-cycle pulse invalidates the whole cache. On the bus side, the memory responder reports two things with the first beat of every transfer: whether it can continue a burst, and whether the access must bypass the cache. The cache adapts to both without retrying the access and without adding latency.

Top module: `wt_dcache`

## Requirements
- R1: After reset, `cpu_ack` and `mem_req` are low and no entry is valid, so the first read of any address goes to memory.
- R2: A read that hits is acknowledged one cycle after it is accepted. It returns the cached longword and issues no memory request.
- R3: The tag includes `cpu_super`. A line filled by one privilege level never hits for the other.
- R4: Address bits [7:4] select one of 16 lines, bits [31:8] form the tag and bits [3:2] select the longword. A read of another tag at the same index replaces the line, and each longword has its own valid bit.
- R5: Every store makes exactly one non-burst memory write of one beat. A store to a line held under the same tag and privilege updates that longword, so a later read returns the stored value.
- R6: While `ctl_freeze` is high, hits are still served but no miss allocates a line.
- R7: With `ctl_burst_en` high, a cacheable read miss fetches four beats, starting at the requested longword and wrapping within the line. The requested data is returned and every longword of the line becomes valid.
- R8: If `mem_burst_ok` is low on the first beat, the transfer ends after that beat with the same latency as a single read, and only that longword becomes valid.
- R9: If `mem_inhibit` is high on the first beat, the access is not cached and is neither retried nor delayed. An inhibited store to a cached longword invalidates that longword.
- R10: With `ctl_wr_alloc` high, a store miss allocates the longword and first invalidates any line with the same tag held under the other privilege level. With it low, a store miss allocates nothing and leaves that other entry untouched.
- R11: With `ctl_enable` low, every access goes to memory and nothing is allocated.
- R12: A one-cycle pulse on `ctl_inval_all` clears every valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Cache enable |
| ctl_freeze | input | 1 | Serve hits only, no allocation |
| ctl_burst_en | input | 1 | Request four-beat line fills on read misses |
| ctl_wr_alloc | input | 1 | Write-allocate mode |
| ctl_inval_all | input | 1 | Clear all valid bits |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_super | input | 1 | Privilege code (1 = supervisor) |
| cpu_addr | input | 32 | Logical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| mem_req | output | 1 | Memory request, held across all beats |
| mem_we | output | 1 | Memory write |
| mem_burst | output | 1 | Burst requested |
| mem_addr | output | 32 | Longword-aligned beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Beat completed |
| mem_rdata | input | 32 | Beat read data |
| mem_burst_ok | input | 1 | Responder can continue the burst (first beat) |
| mem_inhibit | input | 1 | Access must not be cached (first beat) |

## Verification
The main function is exercised with repeated reads of one address, reads of the same address at both privilege levels, reads of two tags that share an index, and reads of neighbouring longwords in a line. These patterns separate a tag compare that includes the privilege bit, a correct index and word split, and per-longword validity. Burst fills start at a middle longword so that the wrap order and the whole-line fill can be seen. The same miss is then repeated with burst refusal and with the inhibit signal, which must both end in one beat. Stores are issued across the other privilege level both with and without write-allocate, so a stale hit that only the non-allocating mode allows is visible at the read port.

// File: rtl/wtdc_pkg.sv
package wtdc_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned LINES    = 16;
    localparam int unsigned WORDS    = 4;
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned OFS_W    = $clog2(LANES);
    localparam int unsigned WSEL_W   = $clog2(WORDS);
    localparam int unsigned IDX_W    = $clog2(LINES);
    localparam int unsigned TAG_W    = ADDR_W - IDX_W - WSEL_W - OFS_W;
    localparam int unsigned WSEL_LSB = OFS_W;
    localparam int unsigned IDX_LSB  = OFS_W + WSEL_W;
    localparam int unsigned TAG_LSB  = IDX_LSB + IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORDS-1:0]  wvld_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_ACK  = 2'd2
    } dc_state_e;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        wsel_t wsel;
    } dc_addr_t;

    // One update to the line store per cycle
    typedef struct packed {
        logic  kill_line;
        logic  new_line;
        logic  wr_word;
        logic  kill_word;
        idx_t  idx;
        wsel_t wsel;
        tag_t  tag;
        logic  fc;
        word_t data;
    } dc_cmd_t;

    function automatic dc_addr_t dc_split(input addr_t a);
        dc_addr_t r;
        r.tag  = a[TAG_LSB +: TAG_W];
        r.idx  = a[IDX_LSB +: IDX_W];
        r.wsel = a[WSEL_LSB +: WSEL_W];
        return r;
    endfunction

    function automatic addr_t dc_join(input tag_t t, input idx_t i, input wsel_t w);
        return {t, i, w, {OFS_W{1'b0}}};
    endfunction

endpackage

// File: rtl/wtdc_store.sv
module wtdc_store
    import wtdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    inval_all,
    input  dc_cmd_t cmd,
    input  idx_t    rd_idx,
    input  wsel_t   rd_wsel,
    output tag_t    rd_tag,
    output logic    rd_fc,
    output wvld_t   rd_vld,
    output word_t   rd_data
);

    tag_t  tag_q [LINES];
    logic  fc_q  [LINES];
    wvld_t vld_q [LINES];
    word_t dat_q [LINES][WORDS];

    wvld_t vld_nxt;
    logic  vld_touch;
    logic  any_v;

    assign rd_tag  = tag_q[rd_idx];
    assign rd_fc   = fc_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign rd_data = dat_q[rd_idx][rd_wsel];

    assign vld_touch = cmd.kill_line | cmd.new_line | cmd.wr_word | cmd.kill_word;

    always_comb begin
        vld_nxt = vld_q[cmd.idx];
        if (cmd.kill_line || cmd.new_line) vld_nxt = '0;
        if (cmd.wr_word)   vld_nxt[cmd.wsel] = 1'b1;
        if (cmd.kill_word) vld_nxt[cmd.wsel] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                vld_q[i] <= '0;
                tag_q[i] <= '0;
                fc_q[i]  <= 1'b0;
            end
        end else if (inval_all) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
        end else begin
            if (vld_touch) vld_q[cmd.idx] <= vld_nxt;
            if (cmd.new_line) begin
                tag_q[cmd.idx] <= cmd.tag;
                fc_q[cmd.idx]  <= cmd.fc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (cmd.wr_word) dat_q[cmd.idx][cmd.wsel] <= cmd.data;
    end

    always_comb begin
        any_v = 1'b0;
        for (int i = 0; i < LINES; i++) any_v = any_v | (|vld_q[i]);
    end

    AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !any_v); // R12

endmodule

// File: rtl/wtdc_ctrl.sv
module wtdc_ctrl
    import wtdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ctl_enable,
    input  logic    ctl_freeze,
    input  logic    ctl_burst_en,
    input  logic    ctl_wr_alloc,
    input  logic    cpu_req,
    input  logic    cpu_we,
    input  logic    cpu_super,
    input  addr_t   cpu_addr,
    input  word_t   cpu_wdata,
    output logic    cpu_ack,
    output word_t   cpu_rdata,
    output logic    mem_req,
    output logic    mem_we,
    output logic    mem_burst,
    output addr_t   mem_addr,
    output word_t   mem_wdata,
    input  logic    mem_ack,
    input  word_t   mem_rdata,
    input  logic    mem_burst_ok,
    input  logic    mem_inhibit,
    output idx_t    rd_idx,
    output wsel_t   rd_wsel,
    input  tag_t    rd_tag,
    input  logic    rd_fc,
    input  wvld_t   rd_vld,
    input  word_t   rd_data,
    output dc_cmd_t cmd
);

    localparam wsel_t LAST_BEAT = wsel_t'(WORDS - 1);

    dc_state_e state_q;
    dc_addr_t  rq_q;
    logic      fc_q, we_q;
    word_t     wdata_q, rdata_q;
    wsel_t     beat_q;
    logic      burst_q, alloc_q, cached_q, keep_q;

    dc_addr_t  ca;
    tag_t      look_tag;
    logic      look_fc;
    logic      same_tag, own_line, other_line, hit;
    wsel_t     cur_wsel;
    logic      last_beat;

    assign ca       = dc_split(cpu_addr);
    assign rd_idx   = (state_q == ST_IDLE) ? ca.idx : rq_q.idx;
    assign rd_wsel  = ca.wsel;
    assign look_tag = (state_q == ST_IDLE) ? ca.tag : rq_q.tag;
    assign look_fc  = (state_q == ST_IDLE) ? cpu_super : fc_q;

    assign same_tag   = (rd_tag == look_tag);
    assign own_line   = same_tag && (rd_fc == look_fc);
    assign other_line = same_tag && (rd_fc != look_fc) && (|rd_vld);
    assign hit        = ctl_enable && own_line && rd_vld[ca.wsel];

    assign cur_wsel = rq_q.wsel + beat_q;

    assign mem_req   = (state_q == ST_BUS);
    assign mem_we    = we_q;
    assign mem_burst = burst_q;
    assign mem_addr  = dc_join(rq_q.tag, rq_q.idx, cur_wsel);
    assign mem_wdata = wdata_q;
    assign cpu_ack   = (state_q == ST_ACK);
    assign cpu_rdata = rdata_q;

    // First beat decides continuation; later beats run to the end of the line
    assign last_beat = (beat_q == '0) ? !(burst_q && mem_burst_ok && !mem_inhibit)
                                      : (beat_q == LAST_BEAT);

    always_comb begin
        cmd      = '0;
        cmd.idx  = rq_q.idx;
        cmd.tag  = rq_q.tag;
        cmd.fc   = fc_q;
        cmd.wsel = cur_wsel;
        cmd.data = we_q ? wdata_q : mem_rdata;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we && ctl_enable && ctl_wr_alloc && other_line) begin
                    cmd.kill_line = 1'b1;
                    cmd.idx       = ca.idx;
                end
            end
            ST_BUS: begin
                if (mem_ack) begin
                    if (!we_q) begin
                        if (beat_q == '0) begin
                            if (alloc_q && !mem_inhibit) begin
                                cmd.new_line = !own_line;
                                cmd.wr_word  = 1'b1;
                            end
                        end else if (keep_q) begin
                            cmd.wr_word = 1'b1;
                        end
                    end else if (cached_q) begin
                        if (own_line) begin
                            cmd.kill_word = mem_inhibit;
                            cmd.wr_word   = !mem_inhibit;
                        end else if (alloc_q && !mem_inhibit) begin
                            cmd.new_line = 1'b1;
                            cmd.wr_word  = 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            rq_q     <= '0;
            fc_q     <= 1'b0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            beat_q   <= '0;
            burst_q  <= 1'b0;
            alloc_q  <= 1'b0;
            cached_q <= 1'b0;
            keep_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        rq_q     <= ca;
                        fc_q     <= cpu_super;
                        we_q     <= cpu_we;
                        wdata_q  <= cpu_wdata;
                        beat_q   <= '0;
                        burst_q  <= !cpu_we && ctl_enable && !ctl_freeze && ctl_burst_en;
                        alloc_q  <= ctl_enable && !ctl_freeze && (!cpu_we || ctl_wr_alloc);
                        cached_q <= ctl_enable;
                        if (!cpu_we && hit) begin
                            rdata_q <= rd_data;
                            state_q <= ST_ACK;
                        end else begin
                            state_q <= ST_BUS;
                        end
                    end
                end
                ST_BUS: begin
                    if (mem_ack) begin
                        if (beat_q == '0) begin
                            if (!we_q) rdata_q <= mem_rdata;
                            keep_q <= alloc_q && !mem_inhibit;
                        end
                        if (last_beat) state_q <= ST_ACK;
                        else           beat_q  <= beat_q + wsel_t'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack); // R2

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_req && !cpu_we && hit) |=> (cpu_ack && !mem_req)); // R2

    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_burst); // R5

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_burst && mem_burst_ok && !mem_inhibit && beat_q != LAST_BEAT)
        |=> (mem_req && mem_addr[WSEL_LSB +: WSEL_W] == wsel_t'($past(mem_addr[WSEL_LSB +: WSEL_W]) + 1))); // R7

    AST_REFUSED_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && beat_q == '0 && !mem_burst_ok) |=> !mem_req); // R8

    AST_INHIBIT_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && beat_q == '0 && mem_inhibit) |-> !cmd.wr_word); // R9

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wtdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_enable,
    input  logic        ctl_freeze,
    input  logic        ctl_burst_en,
    input  logic        ctl_wr_alloc,
    input  logic        ctl_inval_all,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic        cpu_super,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ack,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_burst,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        mem_burst_ok,
    input  logic        mem_inhibit
);

    dc_cmd_t cmd;
    idx_t    rd_idx;
    wsel_t   rd_wsel;
    tag_t    rd_tag;
    logic    rd_fc;
    wvld_t   rd_vld;
    word_t   rd_data;

    wtdc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ctl_enable   (ctl_enable),
        .ctl_freeze   (ctl_freeze),
        .ctl_burst_en (ctl_burst_en),
        .ctl_wr_alloc (ctl_wr_alloc),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_super    (cpu_super),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_ack      (cpu_ack),
        .cpu_rdata    (cpu_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_burst    (mem_burst),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .mem_burst_ok (mem_burst_ok),
        .mem_inhibit  (mem_inhibit),
        .rd_idx       (rd_idx),
        .rd_wsel      (rd_wsel),
        .rd_tag       (rd_tag),
        .rd_fc        (rd_fc),
        .rd_vld       (rd_vld),
        .rd_data      (rd_data),
        .cmd          (cmd)
    );

    wtdc_store u_store (
        .clk       (clk),
        .rst       (rst),
        .inval_all (ctl_inval_all),
        .cmd       (cmd),
        .rd_idx    (rd_idx),
        .rd_wsel   (rd_wsel),
        .rd_tag    (rd_tag),
        .rd_fc     (rd_fc),
        .rd_vld    (rd_vld),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_enable = 1'b0, ctl_freeze = 1'b0, ctl_burst_en = 1'b0;
    logic        ctl_wr_alloc = 1'b0, ctl_inval_all = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_super = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_burst;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_burst_ok = 1'b0, mem_inhibit = 1'b0;
    logic [31:0] mem_rdata = '0;

    // responder configuration
    logic cfg_burst_ok = 1'b1;
    logic cfg_inhibit  = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int beats  = 0;
    logic [31:0] baddr [$];
    logic [31:0] mem [int unsigned];

    // behavioural cache model
    logic [23:0] m_tag [16];
    logic        m_fc  [16];
    logic [3:0]  m_vld [16];
    logic [31:0] m_dat [16][4];

    always #4 clk = ~clk;

    wt_dcache u0 (.*);

    function automatic logic [31:0] mval(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
    endfunction

    // memory responder: zero wait states, decisions given on every beat
    always @(negedge clk) begin
        if (mem_req) begin
            mem_ack      = 1'b1;
            mem_rdata    = mval(mem_addr);
            mem_burst_ok = cfg_burst_ok;
            mem_inhibit  = cfg_inhibit;
            beats++;
            baddr.push_back(mem_addr);
            if (mem_we) mem[mem_addr] = mem_wdata;
        end else begin
            mem_ack      = 1'b0;
            mem_burst_ok = 1'b0;
            mem_inhibit  = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit we, input logic [31:0] addr, input bit fc,
                         input logic [31:0] wd, input string req);
        logic [3:0]  idx;
        logic [1:0]  w;
        logic [23:0] tg;
        logic [31:0] a;
        bit          own, hit, other;
        int          exp_beats, exp_lat, lat;
        logic [31:0] exp_rd;
        a   = {addr[31:2], 2'b00};
        idx = addr[7:4];
        w   = addr[3:2];
        tg  = addr[31:8];
        own   = (m_tag[idx] == tg) && (m_fc[idx] == fc);
        other = (m_tag[idx] == tg) && (m_fc[idx] != fc) && (m_vld[idx] != 4'b0);
        hit   = ctl_enable && !we && own && m_vld[idx][w];
        if (hit) exp_beats = 0;
        else if (!we && ctl_enable && !ctl_freeze && ctl_burst_en && cfg_burst_ok && !cfg_inhibit)
            exp_beats = 4;
        else exp_beats = 1;
        exp_lat = 1 + exp_beats;
        exp_rd  = hit ? m_dat[idx][w] : mval(a);

        // model update
        if (!we) begin
            if (!hit && ctl_enable && !ctl_freeze && !cfg_inhibit) begin
                if (!own) begin m_tag[idx] = tg; m_fc[idx] = fc; m_vld[idx] = 4'b0; end
                if (exp_beats == 4) begin
                    for (int k = 0; k < 4; k++) begin
                        m_dat[idx][k] = mval({tg, idx, 2'(k), 2'b00});
                        m_vld[idx][k] = 1'b1;
                    end
                end else begin
                    m_dat[idx][w] = mval(a);
                    m_vld[idx][w] = 1'b1;
                end
            end
        end else if (ctl_enable) begin
            if (ctl_wr_alloc && other) m_vld[idx] = 4'b0;
            if (own) begin
                if (cfg_inhibit) m_vld[idx][w] = 1'b0;
                else begin m_dat[idx][w] = wd; m_vld[idx][w] = 1'b1; end
            end else if (!ctl_freeze && ctl_wr_alloc && !cfg_inhibit) begin
                m_tag[idx] = tg; m_fc[idx] = fc; m_vld[idx] = 4'b0;
                m_dat[idx][w] = wd; m_vld[idx][w] = 1'b1;
            end
        end

        beats = 0;
        baddr.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_super = fc; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ack && lat < 50);
        cpu_req = 1'b0;
        check(lat == exp_lat, req, "latency", 32'(lat), 32'(exp_lat));
        check(beats == exp_beats, req, "bus beats", 32'(beats), 32'(exp_beats));
        if (!we) check(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
        if (we && beats > 0) check(mem[a] == wd, req, "memory written", mem[a], wd);
        for (int k = 0; k < baddr.size() && k < exp_beats; k++)
            check(baddr[k] == {tg, idx, 2'(w + 2'(k)), 2'b00}, req, "beat address",
                  baddr[k], {tg, idx, 2'(w + 2'(k)), 2'b00});
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_tag[i] = '0; m_fc[i] = 1'b0; m_vld[i] = 4'b0;
            for (int k = 0; k < 4; k++) m_dat[i][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ack == 1'b0, "R1", "ack after reset", 32'(cpu_ack), 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);

        ctl_enable = 1'b1;
        do_op(0, 32'h0000_1234, 0, 0, "R1");          // cold miss
        do_op(0, 32'h0000_1234, 0, 0, "R2");          // hit
        do_op(0, 32'h0000_1234, 1, 0, "R3");          // other privilege misses
        do_op(0, 32'h0000_1234, 1, 0, "R3");
        do_op(0, 32'h0000_5634, 0, 0, "R4");          // same index, new tag
        do_op(0, 32'h0000_1234, 0, 0, "R4");          // evicted
        do_op(0, 32'h0000_1238, 0, 0, "R4");          // neighbour longword not valid
        do_op(1, 32'h0000_1234, 0, 32'hDEAD_0001, "R5");
        do_op(0, 32'h0000_1234, 0, 0, "R5");          // hit returns stored data

        ctl_burst_en = 1'b1;
        do_op(0, 32'h0000_2078, 0, 0, "R7");          // wrap order 2,3,0,1
        do_op(0, 32'h0000_2070, 0, 0, "R7");
        do_op(0, 32'h0000_207C, 0, 0, "R7");

        cfg_burst_ok = 1'b0;
        do_op(0, 32'h0000_30A4, 0, 0, "R8");
        do_op(0, 32'h0000_30A8, 0, 0, "R8");
        cfg_burst_ok = 1'b1;

        cfg_inhibit = 1'b1;
        do_op(0, 32'h0000_40C0, 0, 0, "R9");
        cfg_inhibit = 1'b0;
        do_op(0, 32'h0000_40C0, 0, 0, "R9");          // still a miss
        do_op(0, 32'h0000_40C0, 0, 0, "R9");          // now cached
        cfg_inhibit = 1'b1;
        do_op(1, 32'h0000_40C0, 0, 32'hBEEF_0002, "R9");
        cfg_inhibit = 1'b0;
        do_op(0, 32'h0000_40C0, 0, 0, "R9");          // invalidated longword refetched

        ctl_freeze = 1'b1;
        do_op(0, 32'h0000_2074, 0, 0, "R6");          // hit while frozen
        do_op(0, 32'h0000_50D0, 0, 0, "R6");
        do_op(0, 32'h0000_50D0, 0, 0, "R6");          // no allocation
        ctl_freeze = 1'b0;

        do_op(0, 32'h0000_60E0, 1, 0, "R10");         // supervisor line
        do_op(1, 32'h0000_60E0, 0, 32'hCAFE_0003, "R10");
        do_op(0, 32'h0000_60E0, 1, 0, "R10");         // stale hit without allocate
        ctl_wr_alloc = 1'b1;
        do_op(1, 32'h0000_60E0, 0, 32'hCAFE_0004, "R10");
        do_op(0, 32'h0000_60E0, 0, 0, "R10");         // allocated hit
        do_op(0, 32'h0000_60E0, 1, 0, "R10");         // other entry was invalidated

        ctl_enable = 1'b0;
        do_op(0, 32'h0000_2078, 0, 0, "R11");
        do_op(0, 32'h0000_2078, 0, 0, "R11");
        do_op(1, 32'h0000_2078, 0, 32'h1111_0005, "R11");
        ctl_enable = 1'b1;
        do_op(0, 32'h0000_2074, 0, 0, "R11");         // untouched line still hits

        ctl_inval_all = 1'b1;
        @(negedge clk);
        ctl_inval_all = 1'b0;
        for (int i = 0; i < 16; i++) m_vld[i] = 4'b0;
        do_op(0, 32'h0000_2074, 0, 0, "R12");
        do_op(0, 32'h0000_40C4, 0, 0, "R12");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule